// File: doc/BRIEF.md
# Synchronous Serial Position Reader (Master)

This block is the master end of a clocked serial link to an absolute position sensor. When it receives a read request and the sensor's data line is high (the sensor reports that it is ready), the block drives a burst of clock pulses. The clock idles high and its half-period is set by a divider parameter. The sensor shifts its word out MSB first. The block captures one bit on every rising edge after the first one. It ignores any surplus padding bits, can undo Gray coding, and splits the word into a single-turn position field and an optional turn-count field. After the last rising edge it keeps the clock high for a recovery window before the next read can begin.

The controller is a five-state machine:
- `ST_IDLE` is the rest state. It is left by *go* (a request is present and the data line is high) to `ST_LOW`, or by *stall* (a request is present and the data line is low) to `ST_HOLD`.
- `ST_HOLD` waits for the sensor. It leaves by *ready* to `ST_LOW`.
- `ST_LOW` and `ST_HIGH` alternate through *rise* and *fall*. Each lasts `HALF_DIV` cycles.
- *last-rise* leaves `ST_LOW` for `ST_MONO` after the final edge of the burst.
- `ST_MONO` leaves by *recovered* back to `ST_IDLE` after `MONO_CYC` cycles.

A request that arrives during a burst or during recovery is held and served once the block returns to `ST_IDLE`.

Top module: `ssi_reader`

## Requirements
- R1: After reset, `sclk_out` is 1, `busy` and `done` are 0, and `position` and `turns` are zero.
- R2: A read issues W+1+P rising edges on `sclk_out`. W is the word width: ST_BITS+TURN_BITS, which is 33 by default. P is `pad_clks`. Each low phase and each high phase lasts HALF_DIV cycles, and the first low phase starts one cycle after the request is taken.
- R3: The first rising edge carries no data. On rising edge k, for k from 2 to W+1, the block captures `sdata_in` as word bit W+1-k, so the MSB comes first. The upper TURN_BITS bits of the word (sent first) go to `turns` and the lower ST_BITS bits go to `position`.
- R4: Bits captured on edges after edge W+1 (the padding zeros) are discarded. The result is the same for every value of `pad_clks`.
- R5: If `gray_en` is 1 when the read begins, the W-bit word is converted from Gray to binary before the split. The conversion works from the MSB downward: each binary bit is the XOR of all received bits from the MSB down to and including itself. If `gray_en` is 0, the word is used unchanged.
- R6: If `sdata_in` is 0 when a request is taken, no clock edge is issued and `busy` stays 1 until `sdata_in` is 1. The burst then starts.
- R7: Between the last rising edge of one read and the first falling edge of the next read there are at least MONO_CYC cycles. A request made during a read or during recovery is not lost and is served afterwards.
- R8: `done` is a one-cycle pulse that comes one cycle after the last rising edge. `position` and `turns` change only in the cycle in which `done` is 1.
- R9: `busy` is 1 from the cycle after a request is taken until the block is back in `ST_IDLE` with no request pending. `sclk_out` is never 0 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Read request, one cycle |
| gray_en | input | 1 | Word is Gray coded; sampled when the read begins |
| pad_clks | input | PAD_W | Number of surplus clock edges after the word |
| sdata_in | input | 1 | Serial data from the sensor; high means ready |
| sclk_out | output | 1 | Serial clock to the sensor, idle high |
| busy | output | 1 | A read is in progress, pending or recovering |
| done | output | 1 | One-cycle pulse when the results update |
| position | output | ST_BITS | Single-turn position |
| turns | output | TURN_BITS | Turn count (zero when the turn field is disabled) |

## Verification
`busy` and the first fall of `sclk_out` follow one cycle after the cycle in which `start` is sampled. Each clock phase then lasts exactly HALF_DIV cycles. `done`, `position` and `turns` change together one cycle after the final rising edge. The bench drives its inputs and samples its outputs on the falling edge of the system clock, so each result is read in the first cycle it is due. The model sensor runs on `sclk_out` edges: it counts rising edges and times phases and the recovery gap with simulation time. This means edge count, half-period and recovery-gap checks do not depend on which process runs first at a system clock edge.

// File: rtl/ssi_rd_pkg.sv
package ssi_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_LOW,
        ST_HIGH,
        ST_MONO
    } rd_state_e;

    function automatic int word_width(int st_bits, int turn_bits, bit turns_en);
        return st_bits + (turns_en ? turn_bits : 0);
    endfunction

endpackage

// File: rtl/ssi_half_timer.sv
module ssi_half_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/ssi_shift_in.sv
module ssi_shift_in #(
    parameter int W = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift) begin
            word <= {word[W-2:0], din};
        end
    end
endmodule

// File: rtl/ssi_word_decode.sv
module ssi_word_decode #(
    parameter int ST_BITS   = 17,
    parameter int TURN_BITS = 16,
    parameter bit TURNS_EN  = 1'b1,
    parameter int W         = 33
) (
    input  logic [W-1:0]         raw,
    input  logic                 gray,
    output logic [ST_BITS-1:0]   pos,
    output logic [TURN_BITS-1:0] turns
);
    logic [W-1:0] folded;
    logic [W-1:0] word;

    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            acc       = acc ^ raw[i];
            folded[i] = acc;
        end
    end

    assign word = gray ? folded : raw;
    assign pos  = word[ST_BITS-1:0];

    generate
        if (TURNS_EN) begin : g_turns
            assign turns = word[W-1 -: TURN_BITS];
        end else begin : g_no_turns
            assign turns = '0;
        end
    endgenerate
endmodule

// File: rtl/ssi_reader.sv
module ssi_reader
    import ssi_rd_pkg::*;
#(
    parameter int ST_BITS   = 17,
    parameter int TURN_BITS = 16,
    parameter bit TURNS_EN  = 1'b1,
    parameter int HALF_DIV  = 4,
    parameter int MONO_CYC  = 600,
    parameter int PAD_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 gray_en,
    input  logic [PAD_W-1:0]     pad_clks,
    input  logic                 sdata_in,
    output logic                 sclk_out,
    output logic                 busy,
    output logic                 done,
    output logic [ST_BITS-1:0]   position,
    output logic [TURN_BITS-1:0] turns
);
    localparam int W        = word_width(ST_BITS, TURN_BITS, TURNS_EN);
    localparam int EDGE_MAX = W + (1 << PAD_W);
    localparam int EW       = $clog2(EDGE_MAX + 1);
    localparam int MW       = $clog2(MONO_CYC + 1);

    rd_state_e            state, state_n;
    logic                 pend, pend_n;
    logic                 load;
    logic [EW-1:0]        ecnt, ecnt_inc, last_edge;
    logic [MW-1:0]        mcnt;
    logic [PAD_W-1:0]     pad_q;
    logic                 gray_q;
    logic                 tick;
    logic                 shift_go;
    logic [W-1:0]         raw_word;
    logic [ST_BITS-1:0]   dec_pos;
    logic [TURN_BITS-1:0] dec_turns;
    logic                 publish;

    logic                 sclk_q, busy_q, done_q;
    logic [ST_BITS-1:0]   pos_q;
    logic [TURN_BITS-1:0] turns_q;

    assign ecnt_inc  = ecnt + EW'(1);
    assign last_edge = EW'(W + 1) + EW'(pad_q);
    assign shift_go  = (state == ST_LOW) && tick
                       && (ecnt_inc >= EW'(2)) && (ecnt_inc <= EW'(W + 1));
    assign publish   = (state == ST_MONO) && (mcnt == '0);

    ssi_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((state == ST_LOW) || (state == ST_HIGH)),
        .tick  (tick)
    );

    ssi_shift_in #(.W(W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (shift_go),
        .din   (sdata_in),
        .word  (raw_word)
    );

    ssi_word_decode #(
        .ST_BITS   (ST_BITS),
        .TURN_BITS (TURN_BITS),
        .TURNS_EN  (TURNS_EN),
        .W         (W)
    ) u_decode (
        .raw   (raw_word),
        .gray  (gray_q),
        .pos   (dec_pos),
        .turns (dec_turns)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        pend_n  = pend;
        load    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start || pend) begin
                    pend_n = 1'b0;
                    if (sdata_in) begin
                        state_n = ST_LOW;
                        load    = 1'b1;
                    end else begin
                        state_n = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (sdata_in) begin
                    state_n = ST_LOW;
                    load    = 1'b1;
                end
            end
            ST_LOW: begin
                if (start) pend_n = 1'b1;
                if (tick) begin
                    state_n = (ecnt_inc == last_edge) ? ST_MONO : ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (start) pend_n = 1'b1;
                if (tick) state_n = ST_LOW;
            end
            ST_MONO: begin
                if (start) pend_n = 1'b1;
                if (mcnt == MW'(MONO_CYC - 1)) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            pend   <= 1'b0;
            ecnt   <= '0;
            mcnt   <= '0;
            pad_q  <= '0;
            gray_q <= 1'b0;
        end else begin
            state <= state_n;
            pend  <= pend_n;
            if (load) begin
                ecnt   <= '0;
                pad_q  <= pad_clks;
                gray_q <= gray_en;
            end else if ((state == ST_LOW) && tick) begin
                ecnt <= ecnt_inc;
            end
            if (state == ST_MONO) begin
                mcnt <= mcnt + MW'(1);
            end else begin
                mcnt <= '0;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b1;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            pos_q   <= '0;
            turns_q <= '0;
        end else begin
            sclk_q <= (state_n != ST_LOW);
            busy_q <= (state_n != ST_IDLE) || pend_n;
            done_q <= publish;
            if (publish) begin
                pos_q   <= dec_pos;
                turns_q <= dec_turns;
            end
        end
    end

    assign sclk_out = sclk_q;
    assign busy     = busy_q;
    assign done     = done_q;
    assign position = pos_q;
    assign turns    = turns_q;
endmodule

// File: rtl/ssi_reader_chk.sv
module ssi_reader_chk
    import ssi_rd_pkg::*;
#(
    parameter int ST_BITS   = 17,
    parameter int TURN_BITS = 16,
    parameter int HALF_DIV  = 4,
    parameter int MONO_CYC  = 600
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sclk_out,
    input logic                 busy,
    input logic                 done,
    input logic [ST_BITS-1:0]   position,
    input logic [TURN_BITS-1:0] turns,
    input rd_state_e            state
);
    localparam int GW  = $clog2(MONO_CYC + HALF_DIV + 2);
    localparam int SAT = MONO_CYC + HALF_DIV + 1;

    logic          sclk_prev;
    logic [GW-1:0] gap;
    logic          mono_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev <= 1'b1;
            gap       <= GW'(SAT);
            mono_seen <= 1'b0;
        end else begin
            sclk_prev <= sclk_out;
            if (sclk_out && !sclk_prev) begin
                gap <= GW'(1);
            end else if (gap != GW'(SAT)) begin
                gap <= gap + GW'(1);
            end
            if (state == ST_MONO) begin
                mono_seen <= 1'b1;
            end else if (!sclk_out && sclk_prev) begin
                mono_seen <= 1'b0;
            end
        end
    end

    // R9: the serial clock only goes low during a read
    p_clk_high_when_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_out);

    // R6: no edges while waiting for the sensor
    p_hold_no_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> sclk_out);

    // R8: done lasts one cycle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: results move only with done
    p_result_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(position) || !$stable(turns)) |-> done);

    // R2: each high phase lasts at least HALF_DIV cycles
    p_high_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_out && sclk_prev) |-> (gap >= GW'(HALF_DIV)));

    // R7: recovery window before the next read's first fall
    p_monoflop_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_out && sclk_prev && mono_seen) |-> (gap >= GW'(MONO_CYC)));
endmodule

bind ssi_reader ssi_reader_chk #(
    .ST_BITS   (ST_BITS),
    .TURN_BITS (TURN_BITS),
    .HALF_DIV  (HALF_DIV),
    .MONO_CYC  (MONO_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_out (sclk_out),
    .busy     (busy),
    .done     (done),
    .position (position),
    .turns    (turns),
    .state    (state)
);

// File: tb/ssi_reader_tb.sv
`timescale 1ns/1ps
module ssi_reader_tb;
    localparam int ST_BITS   = 17;
    localparam int TURN_BITS = 16;
    localparam int W         = ST_BITS + TURN_BITS;
    localparam int HALF_DIV  = 4;
    localparam int MONO_CYC  = 600;
    localparam int PAD_W     = 4;
    localparam int SLAVE_MONO = 300;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 gray_en = 1'b0;
    logic [PAD_W-1:0]     pad_clks = '0;
    logic                 sdata = 1'b1;
    logic                 sclk_out, busy, done;
    logic [ST_BITS-1:0]   position;
    logic [TURN_BITS-1:0] turns;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] tx = '0;
    int  cur_pad = 0;
    int  ecount = 0;
    time fall_t = 0;
    time end_t = 0;
    bit  mono_pending = 1'b0;

    always #10 clk = ~clk;

    ssi_reader #(
        .ST_BITS(ST_BITS), .TURN_BITS(TURN_BITS), .TURNS_EN(1'b1),
        .HALF_DIV(HALF_DIV), .MONO_CYC(MONO_CYC), .PAD_W(PAD_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .gray_en(gray_en),
        .pad_clks(pad_clks), .sdata_in(sdata), .sclk_out(sclk_out),
        .busy(busy), .done(done), .position(position), .turns(turns)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // model sensor
    always @(posedge sclk_out) begin
        if (rst_n) begin
            ecount++;
            if (ecount == 1) begin
                chk(($time - fall_t) == HALF_DIV * 20, "R2 low phase",
                    longint'(($time - fall_t) / 20), HALF_DIV);
            end
            #1;
            if (ecount <= W) sdata = tx[W - ecount];
            else sdata = 1'b0;
            if (ecount == W + 1 + cur_pad) begin
                end_t = $time - 1;
                mono_pending = 1'b1;
                repeat (SLAVE_MONO) @(posedge clk);
                sdata = 1'b1;
            end
        end
    end

    always @(negedge sclk_out) begin
        if (rst_n) begin
            if (ecount == 0) fall_t = $time;
            if (mono_pending) begin
                chk(($time - end_t) / 20 >= MONO_CYC, "R7 recovery gap",
                    longint'(($time - end_t) / 20), MONO_CYC);
                mono_pending = 1'b0;
            end
        end
    end

    task automatic do_read(input logic [W-1:0] w, input bit g, input int pad, input bit hold);
        tx = g ? to_gray(w) : w;
        cur_pad = pad;
        @(negedge clk);
        ecount = 0;
        gray_en = g;
        pad_clks = PAD_W'(pad);
        if (hold) sdata = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after request", busy, 1);
        if (hold) begin
            bit ok = 1'b1;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (!sclk_out || !busy) ok = 1'b0;
            end
            chk(ok, "R6 no clock while sensor not ready", ok, 1);
            chk(ecount == 0, "R6 edge count during hold", ecount, 0);
            sdata = 1'b1;
        end
        while (!done) @(negedge clk);
        chk(position == w[ST_BITS-1:0], g ? "R5 gray position" : (pad != 0 ? "R4 padded position" : "R3 position"),
            position, w[ST_BITS-1:0]);
        chk(turns == w[W-1:ST_BITS], g ? "R5 gray turns" : "R3 turns", turns, w[W-1:ST_BITS]);
        chk(ecount == W + 1 + pad, "R2 rising edge count", ecount, W + 1 + pad);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] r;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sclk_out == 1'b1, "R1 clock idle", sclk_out, 1);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(position == '0 && turns == '0, "R1 results", {turns, position}, 0);

        do_read({W{1'b1}}, 1'b0, 0, 1'b0);
        do_read(33'h1_2345_6789, 1'b0, 0, 1'b0);
        do_read(33'h1_2345_6789, 1'b0, 15, 1'b0);      // R4 max padding
        do_read(33'h0_0000_0001, 1'b1, 0, 1'b0);       // R5 gray, LSB only
        do_read(33'h1_0000_0000, 1'b1, 3, 1'b0);       // R5 gray, MSB only
        while (busy) @(negedge clk);
        do_read(33'h0_ABCD_1234, 1'b0, 2, 1'b1);       // R6 sensor not ready

        for (int n = 0; n < 30; n++) begin
            r = {$urandom(), $urandom()};
            do_read(r[W-1:0], 1'($urandom() & 1), int'($urandom() % 16), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule